// File: doc/BRIEF.md
# Multiplier with Signed Correction Sequencer

This block forms an 8 x 8 product in a 16-bit result register that is read out as a high byte and a low byte. In unsigned mode the product is ready one clock after the start strobe. In signed mode the block does not use a signed multiplier array. It runs one unsigned multiply and then applies up to two conditional subtractions to the high byte only. If the second operand is negative, the first operand is subtracted from the high byte. If the first operand is negative, the second operand is subtracted from the high byte. These steps run as a fixed sequence, so the latency does not depend on the operand values.

The operands are latched when a start is accepted. The result register keeps its value until the next accepted start. A single-cycle done pulse marks the point at which the result is final. The block has no status flags: it drives no carry, zero or overflow output.

Top module: `mulseq`

## Requirements
- R1: With signed_i=0, an accepted start loads {prod_hi_o, prod_lo_o} with the unsigned product of op_a_i and op_b_i at the same clock edge. done_o is high in the following cycle, and busy_o stays low.
- R2: With signed_i=1, the result after done_o equals the two's-complement product of the two operands, as a 16-bit value.
- R3: The signed correction subtracts op_a from the high byte when op_b bit 7 is 1, and then subtracts op_b when op_a bit 7 is 1. Each subtraction is modulo 256 and discards the borrow. For example, -128 x -128 gives 16'h4000.
- R4: The low product byte does not change during the correction steps of a signed sequence.
- R5: A signed start is accepted at clock edge N, and done_o is high in the cycle after edge N+5, giving 6 cycles whatever the operand signs. busy_o is high for exactly the 5 cycles before that.
- R6: done_o is high for exactly one cycle per accepted start and is never high together with busy_o.
- R7: Operands are captured when a start is accepted. Changes on op_a_i, op_b_i or signed_i during a signed sequence do not affect the result.
- R8: A start while busy_o is high is ignored. The running sequence keeps its latency and result.
- R9: After reset, prod_hi_o and prod_lo_o are 0 and busy_o and done_o are low.
- R10: The product outputs hold their value while no start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| signed_i | input | 1 | 1: signed product, 0: unsigned product |
| op_a_i | input | 8 | First operand |
| op_b_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | High byte of the product register |
| prod_lo_o | output | 8 | Low byte of the product register |
| busy_o | output | 1 | Signed sequence in progress |
| done_o | output | 1 | Product register holds the final result |

## Verification
A sequencer that skips or repeats a state shows up in the first signed operation. done_o arrives in a cycle other than the sixth, and busy_o is high for a count other than five. Both are visible within seven cycles of the start. A subtraction with the wrong operand, or one gated by the wrong sign bit, corrupts only the high byte, and only for operands with the matching sign pattern. A sweep over mixed-sign pairs exposes it on the first such pair. An operand register that is not held is caught by changing the inputs during busy_o and comparing the result one done pulse later.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MUL   = 3'd1,
    ST_CHK_B = 3'd2,
    ST_SUB_A = 3'd3,
    ST_CHK_A = 3'd4,
    ST_SUB_B = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/mulseq_array.sv
module mulseq_array #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pp [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b_i[i] ? (PW'(a_i) << i) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++) p_o = p_o + pp[i];
  end
endmodule

// File: rtl/mulseq_hisub.sv
module mulseq_hisub #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] sub_i,
  input  logic         en_i,
  output logic [W-1:0] hi_o
);
  // modulo 2^W, borrow dropped
  assign hi_o = en_i ? (hi_i - sub_i) : hi_i;
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       signed_i,
  output logic       accept_o,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = (accept_o && signed_i) ? ST_MUL : ST_IDLE;
      ST_MUL:           state_d = ST_CHK_B;
      ST_CHK_B:         state_d = ST_SUB_A;
      ST_SUB_A:         state_d = ST_CHK_A;
      ST_CHK_A:         state_d = ST_SUB_B;
      ST_SUB_B:         state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mulseq.sv
module mulseq
  import mulseq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int PW = 2 * W;

  seq_state_e    state;
  logic          accept;
  logic [W-1:0]  a_q, b_q, hi_q, lo_q;
  logic          done_u_q;
  logic [W-1:0]  mul_a, mul_b, sub_val, hi_new;
  logic          sub_en;
  logic [PW-1:0] mul_p;

  mulseq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .signed_i (signed_i),
    .accept_o (accept),
    .state_o  (state)
  );

  // MUL state reuses captured operands; otherwise the live inputs (unsigned path)
  assign mul_a = (state == ST_MUL) ? a_q : op_a_i;
  assign mul_b = (state == ST_MUL) ? b_q : op_b_i;

  mulseq_array #(.W(W)) u_array (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (mul_p)
  );

  assign sub_val = (state == ST_SUB_A) ? a_q : b_q;
  assign sub_en  = (state == ST_SUB_A) ? b_q[W-1] : a_q[W-1];

  mulseq_hisub #(.W(W)) u_hisub (
    .hi_i  (hi_q),
    .sub_i (sub_val),
    .en_i  (sub_en),
    .hi_o  (hi_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      done_u_q <= 1'b0;
    end else begin
      done_u_q <= accept && !signed_i;
      if (accept && signed_i) begin
        a_q <= op_a_i;
        b_q <= op_b_i;
      end
      if (accept && !signed_i) begin
        {hi_q, lo_q} <= mul_p;
      end else if (state == ST_MUL) begin
        {hi_q, lo_q} <= mul_p;
      end else if (state == ST_SUB_A || state == ST_SUB_B) begin
        hi_q <= hi_new;
      end
    end
  end

  assign prod_hi_o = hi_q;
  assign prod_lo_o = lo_q;
  assign busy_o    = (state != ST_IDLE) && (state != ST_DONE);
  assign done_o    = done_u_q || (state == ST_DONE);
endmodule

// File: rtl/mulseq_checker.sv
module mulseq_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] prod_lo_o,
  input logic         busy_o,
  input logic         done_o
);
  logic [3:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 busy_cnt <= '0;
    else if (!busy_o)            busy_cnt <= '0;
    else if (busy_cnt != 4'hf)   busy_cnt <= busy_cnt + 4'd1;
  end

  p_unsigned_one_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !signed_i) |=> (done_o && !busy_o));

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == 4'd5));

  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  p_lo_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && busy_cnt >= 4'd2) |-> $stable(prod_lo_o));

  p_lo_hold_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $stable(prod_lo_o));

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && busy_cnt < 4'd4) |=> busy_o);
endmodule

bind mulseq mulseq_checker #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .prod_lo_o (prod_lo_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/mulseq_bench.sv
module mulseq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sgn = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] hi, lo;
  logic       busy, done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mulseq u_mulseq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .signed_i  (sgn),
    .op_a_i    (a),
    .op_b_i    (b),
    .prod_hi_o (hi),
    .prod_lo_o (lo),
    .busy_o    (busy),
    .done_o    (done)
  );

  // {signed, a, b, expected}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h00, 16'h0000},
    {1'b0, 8'hff, 8'hff, 16'hfe01},
    {1'b0, 8'h80, 8'h7f, 16'h3f80},
    {1'b1, 8'h80, 8'h80, 16'h4000},
    {1'b1, 8'hff, 8'hff, 16'h0001},
    {1'b1, 8'h80, 8'h7f, 16'hc080},
    {1'b1, 8'h7f, 8'h7f, 16'h3f01},
    {1'b1, 8'hff, 8'h01, 16'hffff}
  };

  function automatic logic [15:0] ref_prod(input logic s, input logic [7:0] x, input logic [7:0] y);
    if (s) return 16'($signed({{8{x[7]}}, x}) * $signed({{8{y[7]}}, y}));
    else   return {8'h00, x} * {8'h00, y};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start at a negedge; returns edges until done and busy cycles seen
  task automatic run_op(input logic s, input logic [7:0] x, input logic [7:0] y,
                        output int lat, output int busy_n);
    @(negedge clk);
    sgn = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; busy_n = busy ? 1 : 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (busy) busy_n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat, bn;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {hi, lo, 6'd0, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table
    for (int i = 0; i < 8; i++) begin
      run_op(VEC[i][32], VEC[i][31:24], VEC[i][23:16], lat, bn);
      check(VEC[i][32] ? "R2 R3 table" : "R1 table", {hi, lo}, VEC[i][15:0]);
      check(VEC[i][32] ? "R5 latency" : "R1 latency", lat, VEC[i][32] ? 6 : 1);
      check("R5 busy count", bn, VEC[i][32] ? 5 : 0);
      @(negedge clk);
      check("R6 single pulse", done, 0);
    end

    // R1 exhaustive unsigned, back-to-back starts
    sgn = 1'b0;
    for (int i = 0; i <= 65536; i++) begin
      logic [7:0] pa, pb;
      pa = a; pb = b;
      if (i > 0) begin
        check("R1 sweep", {hi, lo}, ref_prod(1'b0, pa, pb));
        check("R1 done", done, 1);
      end
      if (i < 65536) begin
        a = 8'(i >> 8); b = 8'(i); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;

    // R2 R3 signed sweep: all a, every 17th b plus 0x80 and 0xff
    for (int x = 0; x < 256; x++) begin
      for (int k = 0; k < 17; k++) begin
        logic [7:0] y;
        y = (k == 16) ? 8'h80 : 8'(k * 17);
        run_op(1'b1, 8'(x), y, lat, bn);
        check("R2 sweep", {hi, lo}, ref_prod(1'b1, 8'(x), y));
        if (lat != 6) check("R5 sweep latency", lat, 6);
      end
    end

    // R7 inputs change during sequence
    @(negedge clk);
    sgn = 1'b1; a = 8'h85; b = 8'h13; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = 8'h01; b = 8'hff; sgn = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 done", done, 1);
    check("R7 captured", {hi, lo}, ref_prod(1'b1, 8'h85, 8'h13));

    // R8 start while busy ignored
    @(negedge clk);
    sgn = 1'b1; a = 8'hc0; b = 8'h90; start = 1'b1;
    @(negedge clk);
    sgn = 1'b0; a = 8'h22; b = 8'h33; // start held high across busy cycles
    repeat (2) @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R8 latency", lat, 6);
    check("R8 result", {hi, lo}, ref_prod(1'b1, 8'hc0, 8'h90));

    // R10 hold
    held = {hi, lo};
    repeat (10) @(negedge clk);
    check("R10 hold", {hi, lo}, held);
    check("R10 idle", {busy, done}, 2'b00);

    // R4 low byte steady during correction
    @(negedge clk);
    sgn = 1'b1; a = 8'h9b; b = 8'hd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    held = {hi, lo};
    check("R4 mul low", lo, ref_prod(1'b0, 8'h9b, 8'hd7) & 16'hff);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R4 low steady", lo, held[7:0]);
    end
    check("R3 final", {hi, lo}, ref_prod(1'b1, 8'h9b, 8'hd7));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule